// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares the rising edges of a divided reference and a divided feedback signal, both sampled on a fast system clock, and encodes the phase error as two pulse outputs. `up` is high while the feedback lags the reference, and `dn` is high while the feedback leads. Once the lagging edge arrives, both outputs stay high together for a programmable number of clock cycles and then clear on the same cycle. This shared tail removes the dead zone around zero phase error. A control input that disables the feedback divider forces the detector into a fixed state: `up` high and `dn` low.

An out-of-lock flag comes from a leaky counter. The counter rises by one on every cycle in which exactly one of `up` and `dn` is high, which is the true phase-error time. It falls by one every 2^LEAK_SHIFT cycles otherwise. The flag has separate assert and release thresholds. The shared residual tail carries no phase information, so it never feeds the counter.

Both signal inputs pass through a synchronizer of SYNC_STAGES flops. With the default of 2, an input edge first shows on `up` or `dn` three clock edges after the input changes.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `up`, `dn` and `out_of_lock` are 0.
- R2: When a feedback rising edge follows a reference rising edge by D cycles, `up` is high for D+R consecutive cycles and `dn` is high for R cycles, and both fall on the same cycle. Here R is `resid_cycles`. `up` rises SYNC_STAGES+1 clock edges after the reference input rises.
- R3: When a reference rising edge follows a feedback rising edge by D cycles, `dn` is high for D+R cycles and `up` is high for R cycles, and both fall together.
- R4: Rising edges on both inputs in the same cycle give one pulse of R cycles on both `up` and `dn`.
- R5: A `resid_cycles` value of 0 behaves as 1, so the residual tail is never shorter than one cycle.
- R6: Only rising edges act. A further rising edge on either input is ignored while a pulse is already open on `up` or `dn`, and it is also ignored during the residual tail.
- R7: While `fb_enable` is 0, `up` is 1 and `dn` is 0 from the next clock edge onward. When `fb_enable` returns to 1, both outputs are 0 after the next edge.
- R8: The integrator level rises by one on each cycle in which exactly one of `up` and `dn` is high, and saturates at 2^LVL_W-1 without wrapping. Otherwise it falls by one every 2^LEAK_SHIFT cycles, stopping at 0. `out_of_lock` rises one cycle after the level reaches `lock_set_thr`. Starting from a level of 0, a steady error of `lock_set_thr`+1 cycles sets it.
- R9: Once set, `out_of_lock` stays high until the level is at or below `lock_clr_thr`. This holds even when the level has already dropped under `lock_set_thr`.
- R10: Cycles in which `up` and `dn` are both high never increase the level. A locked loop that produces only residual pulses therefore never sets `out_of_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Divided reference signal (asynchronous) |
| fb_in | input | 1 | Divided feedback signal (asynchronous) |
| fb_enable | input | 1 | 0 means the feedback divider is disabled (synchronous) |
| resid_cycles | input | RES_W | Residual tail length in clock cycles |
| lock_set_thr | input | LVL_W | Integrator level that sets the out-of-lock flag |
| lock_clr_thr | input | LVL_W | Integrator level at or below which the flag clears; below `lock_set_thr` |
| up | output | 1 | Feedback-lags pulse |
| dn | output | 1 | Feedback-leads pulse |
| out_of_lock | output | 1 | Out-of-lock flag |

## Verification
Pulse results are due three edges after an input edge, plus the lag, plus R cycles. A scoreboard therefore does not time them against an absolute cycle. It measures the width of each `up` and `dn` pulse as a whole event and compares the widths with the values the driver queued when it made the edges. Any pulse that arrives with nothing queued counts as a failure, so an edge that should have been ignored cannot go unseen. `fb_enable` acts on the very next edge, and the flag lags the level by one cycle. The bench checks both by counting edges from the driving negedge: the flag must be low exactly `lock_set_thr`+1 edges into a steady error and high one edge later. Checks of hysteresis and decay are sampled at points where the leak phase cannot change the outcome.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
// Shared types for the phase-frequency detector.
package pfd_pkg;

    // Detector state: idle, one-sided error, residual tail, divider-disabled hold.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UP    = 3'd1,
        ST_DN    = 3'd2,
        ST_RESID = 3'd3,
        ST_HOLD  = 3'd4
    } pfd_state_t;

endpackage

// File: rtl/pfd_edge_det.sv
`timescale 1ns/1ps
// Synchronizes one asynchronous input and flags its rising edges.
// Assumes SYNC_STAGES >= 1. rise_o is a one-cycle pulse, valid
// SYNC_STAGES edges after the input goes high.
module pfd_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single sampling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sig_in;
            end
        end else begin : g_chain
            // Shift chain of sampling flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

    // R6: an edge is reported for one cycle only.
    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_detector_core.sv
`timescale 1ns/1ps
// Phase-frequency detector state machine with a residual tail.
// Takes one-cycle rise strobes. Edges that arrive while a pulse or the
// tail is open are ignored. A tail of 0 cycles is stretched to 1.
// fb_enable is assumed synchronous to clk.
module pfd_detector_core
    import pfd_pkg::*;
#(
    parameter int RES_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic             fb_enable,
    input  logic [RES_W-1:0] resid_cycles,
    output logic             up_o,
    output logic             dn_o
);

    localparam logic [RES_W-1:0] ONE = RES_W'(1);

    pfd_state_t       state_q;
    logic [RES_W-1:0] tail_cnt_q;

    // Advance the detector state and drive the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            up_o       <= 1'b0;
            dn_o       <= 1'b0;
            tail_cnt_q <= '0;
        end else if (!fb_enable) begin
            state_q    <= ST_HOLD;
            up_o       <= 1'b1;
            dn_o       <= 1'b0;
            tail_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_HOLD: begin
                    state_q <= ST_IDLE;
                    up_o    <= 1'b0;
                    dn_o    <= 1'b0;
                end
                ST_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        state_q    <= ST_RESID;
                        up_o       <= 1'b1;
                        dn_o       <= 1'b1;
                        tail_cnt_q <= ONE;
                    end else if (ref_rise) begin
                        state_q <= ST_UP;
                        up_o    <= 1'b1;
                    end else if (fb_rise) begin
                        state_q <= ST_DN;
                        dn_o    <= 1'b1;
                    end
                end
                ST_UP: begin
                    if (fb_rise) begin
                        state_q    <= ST_RESID;
                        dn_o       <= 1'b1;
                        tail_cnt_q <= ONE;
                    end
                end
                ST_DN: begin
                    if (ref_rise) begin
                        state_q    <= ST_RESID;
                        up_o       <= 1'b1;
                        tail_cnt_q <= ONE;
                    end
                end
                ST_RESID: begin
                    if (tail_cnt_q >= resid_cycles) begin
                        state_q <= ST_IDLE;
                        up_o    <= 1'b0;
                        dn_o    <= 1'b0;
                    end else begin
                        tail_cnt_q <= tail_cnt_q + ONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    up_o    <= 1'b0;
                    dn_o    <= 1'b0;
                end
            endcase
        end
    end

    // R7: a disabled feedback divider forces up high and dn low next cycle.
    p_hold_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_enable |=> (up_o && !dn_o));

    // R2: outside hold entry, dn never ends without up ending too.
    p_fall_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dn_o) && $past(fb_enable)) |-> $fell(up_o));

endmodule

// File: rtl/pfd_lock_integ.sv
`timescale 1ns/1ps
// Leaky integrator of phase-error time with a hysteretic out-of-lock flag.
// Error time is any cycle in which exactly one of up/dn is high, so the
// shared residual tail is excluded. Assumes clr_thr < set_thr.
module pfd_lock_integ #(
    parameter int LVL_W      = 8,
    parameter int LEAK_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic [LVL_W-1:0] set_thr,
    input  logic [LVL_W-1:0] clr_thr,
    output logic             flag_o
);

    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    logic             err;
    logic             leak_tick;
    logic [LVL_W-1:0] level_q;

    assign err = up_i ^ dn_i;

    generate
        if (LEAK_SHIFT == 0) begin : g_leak_every
            assign leak_tick = 1'b1;
        end else begin : g_leak_div
            logic [LEAK_SHIFT-1:0] leak_cnt_q;
            // Free-running prescaler that paces the leak.
            always_ff @(posedge clk) begin
                if (!rst_n) leak_cnt_q <= '0;
                else        leak_cnt_q <= leak_cnt_q + 1'b1;
            end
            assign leak_tick = &leak_cnt_q;
        end
    endgenerate

    // Integrate error time upward and leak downward, saturating both ways.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (err) begin
            if (level_q != LVL_MAX) level_q <= level_q + 1'b1;
        end else if (leak_tick && (level_q != '0)) begin
            level_q <= level_q - 1'b1;
        end
    end

    // Set and release the flag on separate thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag_o <= 1'b0;
        else if (!flag_o && level_q >= set_thr) flag_o <= 1'b1;
        else if (flag_o && level_q <= clr_thr)  flag_o <= 1'b0;
    end

    // R8: the level saturates instead of wrapping.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == LVL_MAX && err) |=> (level_q == LVL_MAX));

    // R8: reaching the set threshold raises the flag next cycle.
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= set_thr) |=> flag_o);

    // R9: a set flag holds while the level stays above the release threshold.
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && level_q > clr_thr) |=> flag_o);

    // R10: residual-only cycles never raise the level.
    p_resid_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && dn_i) |=> (level_q <= $past(level_q)));

endmodule

// File: rtl/pfd_lock_top.sv
`timescale 1ns/1ps
// Top of the phase-frequency detector with lock indicator.
// Both signal inputs are synchronized, edge-detected, compared by the
// detector core, and the resulting pulses feed the lock integrator.
// Assumes the pulse period is longer than the lag plus the residual tail.
module pfd_lock_top #(
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = 6,
    parameter int LVL_W       = 8,
    parameter int LEAK_SHIFT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             fb_enable,
    input  logic [RES_W-1:0] resid_cycles,
    input  logic [LVL_W-1:0] lock_set_thr,
    input  logic [LVL_W-1:0] lock_clr_thr,
    output logic             up,
    output logic             dn,
    output logic             out_of_lock
);

    logic ref_rise;
    logic fb_rise;

    pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (ref_in),
        .rise_o (ref_rise)
    );

    pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (fb_in),
        .rise_o (fb_rise)
    );

    pfd_detector_core #(.RES_W(RES_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_rise     (ref_rise),
        .fb_rise      (fb_rise),
        .fb_enable    (fb_enable),
        .resid_cycles (resid_cycles),
        .up_o         (up),
        .dn_o         (dn)
    );

    pfd_lock_integ #(.LVL_W(LVL_W), .LEAK_SHIFT(LEAK_SHIFT)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (up),
        .dn_i    (dn),
        .set_thr (lock_set_thr),
        .clr_thr (lock_clr_thr),
        .flag_o  (out_of_lock)
    );

endmodule

// File: tb/pfd_lock_top_bench.sv
`timescale 1ns/1ps
module pfd_lock_top_bench;

    localparam int SET_THR = 40;
    localparam int CLR_THR = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       fb_enable = 1'b1;
    logic [5:0] resid_cycles = 6'd4;
    logic [7:0] lock_set_thr = 8'(SET_THR);
    logic [7:0] lock_clr_thr = 8'(CLR_THR);
    logic       up, dn, out_of_lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    up_w;
        int    dn_w;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    pfd_lock_top u_pfd_lock_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_in       (ref_in),
        .fb_in        (fb_in),
        .fb_enable    (fb_enable),
        .resid_cycles (resid_cycles),
        .lock_set_thr (lock_set_thr),
        .lock_clr_thr (lock_clr_thr),
        .up           (up),
        .dn           (dn),
        .out_of_lock  (out_of_lock)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: measures each pulse event and compares it with the queue.
    int cur_up = 0;
    int cur_dn = 0;
    bit in_evt = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_evt = 1'b0; cur_up = 0; cur_dn = 0;
        end else if (up || dn) begin
            in_evt = 1'b1;
            cur_up += int'(up);
            cur_dn += int'(dn);
        end else if (in_evt) begin
            in_evt = 1'b0;
            if (sb_q.size() == 0) begin
                check(1'b0, "R6", "unexpected pulse up width", cur_up, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cur_up == e.up_w, e.tag, "up width", cur_up, e.up_w);
                check(cur_dn == e.dn_w, e.tag, "dn width", cur_dn, e.dn_w);
            end
            cur_up = 0; cur_dn = 0;
        end
    end

    // Driver: pushes the expected widths, then drives the edges.
    // tr/tf: cycle of the ref/fb rising edge; tr2: extra ref edge (<0 none).
    task automatic drive_edges(input int tr, input int tf, input int tr2,
                               input int exp_up, input int exp_dn, input string tag);
        exp_t e;
        e.up_w = exp_up; e.dn_w = exp_dn; e.tag = tag;
        sb_q.push_back(e);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            ref_in = (t >= tr && t < tr + 2) || (tr2 >= 0 && t >= tr2 && t < tr2 + 2);
            fb_in  = (t >= tf && t < tf + 2);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic lag_pair(input int lag, input int r_eff, input string tag);
        if (lag >= 0) drive_edges(0, lag, -1, lag + r_eff, r_eff, tag);
        else          drive_edges(-lag, 0, -1, r_eff, r_eff - lag, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!up && !dn && !out_of_lock, "R1", "outputs in reset",
              int'({up, dn, out_of_lock}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!up && !dn && !out_of_lock, "R1", "outputs after reset",
              int'({up, dn, out_of_lock}), 0);

        // R2 / R3 / R4 with a 4-cycle tail.
        resid_cycles = 6'd4;
        lag_pair(5, 4, "R2");
        lag_pair(1, 4, "R2");
        lag_pair(-7, 4, "R3");
        lag_pair(-1, 4, "R3");
        lag_pair(0, 4, "R4");
        check(!out_of_lock, "R8", "flag after small errors", int'(out_of_lock), 0);

        // R5: zero tail behaves as one cycle.
        resid_cycles = 6'd0;
        lag_pair(3, 1, "R5");
        lag_pair(0, 1, "R5");

        // R6: extra edges during the tail and during an open up pulse.
        resid_cycles = 6'd10;
        drive_edges(0, 0, 4, 10, 10, "R6");
        drive_edges(0, 8, 4, 18, 10, "R6");

        // R10: long residual-only pulses never set the flag.
        resid_cycles = 6'd20;
        for (int k = 0; k < 20; k++) begin
            drive_edges(0, 0, -1, 20, 20, "R10");
            check(!out_of_lock, "R10", "flag on residual-only pulses",
                  int'(out_of_lock), 0);
        end

        // R7 / R8 / R9: hold with the divider disabled.
        resid_cycles = 6'd4;
        repeat (50) @(negedge clk);
        begin
            exp_t e;
            e.up_w = 60; e.dn_w = 0; e.tag = "R7";
            sb_q.push_back(e);
        end
        fb_enable = 1'b0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (i == 1) check(up && !dn, "R7", "hold forces up high dn low",
                              int'({up, dn}), 2);
            if (i == SET_THR + 1) check(!out_of_lock, "R8", "flag before threshold",
                                        int'(out_of_lock), 0);
            if (i == SET_THR + 2) check(out_of_lock, "R8", "flag at threshold",
                                        int'(out_of_lock), 1);
        end
        fb_enable = 1'b1;
        @(negedge clk);
        check(!up && !dn, "R7", "release clears outputs", int'({up, dn}), 0);
        repeat (99) @(negedge clk);
        check(out_of_lock, "R9", "flag held below set threshold",
              int'(out_of_lock), 1);
        repeat (200) @(negedge clk);
        check(!out_of_lock, "R9", "flag released after decay",
              int'(out_of_lock), 0);

        // R8: long hold saturates the level; a wrap would drop the flag.
        begin
            exp_t e;
            e.up_w = 300; e.dn_w = 0; e.tag = "R8";
            sb_q.push_back(e);
        end
        fb_enable = 1'b0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (i >= SET_THR + 2 && !out_of_lock)
                check(1'b0, "R8", "flag dropped during saturation",
                      int'(out_of_lock), 1);
        end
        check(out_of_lock, "R8", "flag after saturation", int'(out_of_lock), 1);
        fb_enable = 1'b1;
        repeat (1200) @(negedge clk);
        check(!out_of_lock, "R8", "level leaks to zero", int'(out_of_lock), 0);

        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R2", "pending expected pulses", sb_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule